// File: doc/BRIEF.md
# Video FIFO DMA Request Throttle

This block decides when a video pixel FIFO asks the memory side for more data. A request opens when the FIFO drops below half full and stays open until the FIFO is full. The block also counts the data words the memory side acknowledges during the current raster. Once that count reaches a programmed per-line word budget, the request is suppressed. This stops the FIFO from prefetching words that belong to the next line. The suppression lasts until the horizontal sync edge that begins the following raster.

Software programs a single control word holding three fields:
- the per-raster word budget;
- a bit that turns the budget off for compatibility;
- a preload-size field.

A preload size of zero also turns the budget off. For a dual-panel screen, software writes double the word count. The block compares against whatever value was written, with no scaling of its own. A control write is held pending and only becomes active at the next sync edge, so the limit never changes in the middle of a line. Counting is in whole 32-bit words.

Top module: `vfifo_dma_throttle`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dma_req` is 0. The word count is zero, so no raster starts out inhibited.
- R2: When not inhibited, a FIFO level below FIFO_DEPTH/2 (8 by default) makes `dma_req` 1 from the next clock edge.
- R3: Once raised, `dma_req` stays 1 while the level is between half and one below FIFO_DEPTH. A level of FIFO_DEPTH (full) drops it on the next edge, and it stays 0 until the level is again below half.
- R4: Each cycle with `dma_ack` high adds one to the raster word count, which saturates at its maximum. While the budget is enforced and the count is at least the active budget, `dma_req` is 0 from the edge on which the count reaches it. This includes a budget of 0, which inhibits the whole raster.
- R5: A rising edge of `hsync` clears the word count to 0 and releases the inhibit. An acknowledge in that same cycle is not counted.
- R6: With the disable bit set, the budget is never enforced. The disable bit is bit 13 of `cfg_wdata`, just above the 13-bit budget field in bits 12:0.
- R7: With the preload field at 0, the budget is never enforced. The preload field is bits 15:14 of `cfg_wdata`.
- R8: A write with `cfg_we` takes effect only at the next rising edge of `hsync`. A write in the same cycle as that edge waits for the edge after it.
- R9: Holding `hsync` high for several cycles causes only one clear. The count is not reset again until `hsync` goes low and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, active high by default |
| fifo_level | input | LVL_W (5) | Current FIFO fill level in words |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W (16) | Control word: budget[12:0], disable[13], preload[15:14] |
| dma_ack | input | 1 | One data word delivered into the FIFO this cycle |
| dma_req | output | 1 | DMA refill request |

## Verification
The bench targets four boundaries:
- **Acknowledge that reaches the budget.** A design that compares against the count before the increment would leave the request up for one extra cycle and overfetch a word.
- **Acknowledge in the same cycle as a sync edge.** A design that counts it would inhibit one word early on the new line.
- **Long sync pulse.** Clearing on the level instead of the edge would never inhibit during a wide sync.
- **Control write in the same cycle as a sync edge.** Letting that write through would change the limit within a raster.

The bench also checks both bypass settings and a zero budget, then runs a long randomized mix against a behavioural reference.

// File: rtl/vft_pkg.sv
package vft_pkg;

   typedef enum logic {
      REQ_IDLE = 1'b0,
      REQ_FILL = 1'b1
   } req_state_e;

   function automatic int unsigned low_water(input int unsigned depth);
      return depth / 2;
   endfunction

endpackage

// File: rtl/vft_cfg_shadow.sv
module vft_cfg_shadow #(
   parameter int unsigned WIDTH_W        = 13,
   parameter int unsigned PRE_W          = 2,
   parameter bit          HSYNC_ACT_HIGH = 1'b1,
   localparam int unsigned CFG_W         = WIDTH_W + 1 + PRE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsync,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic               line_start,
   output logic [WIDTH_W-1:0] width_nxt,
   output logic               enforce_nxt,
   output logic [WIDTH_W-1:0] width_q,
   output logic               enforce_q
);

   localparam int unsigned DIS_BIT = WIDTH_W;
   localparam int unsigned PRE_LSB = WIDTH_W + 1;

   logic             hs_on;
   logic             hs_q;
   logic [CFG_W-1:0] pend_q;
   logic [CFG_W-1:0] act_q;
   logic [CFG_W-1:0] act_nxt;

   generate
      if (HSYNC_ACT_HIGH) begin : g_hs_pos
         assign hs_on = hsync;
      end else begin : g_hs_neg
         assign hs_on = ~hsync;
      end
   endgenerate

   assign line_start = hs_on & ~hs_q;
   assign act_nxt    = line_start ? pend_q : act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= 1'b0;
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         hs_q  <= hs_on;
         act_q <= act_nxt;
         if (cfg_we) pend_q <= cfg_wdata;
      end
   end

   assign width_nxt   = act_nxt[WIDTH_W-1:0];
   assign enforce_nxt = ~act_nxt[DIS_BIT] & (|act_nxt[PRE_LSB +: PRE_W]);
   assign width_q     = act_q[WIDTH_W-1:0];
   assign enforce_q   = ~act_q[DIS_BIT] & (|act_q[PRE_LSB +: PRE_W]);

   initial begin
      assert (WIDTH_W >= 2 && PRE_W >= 1)
         else $error("vft_cfg_shadow: field widths too small");
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(act_q));                                  // R8
   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> act_q == $past(pend_q));                          // R8

endmodule

// File: rtl/vft_word_counter.sv
module vft_word_counter #(
   parameter int unsigned WIDTH_W = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_start,
   input  logic               dma_ack,
   output logic [WIDTH_W-1:0] cnt_q,
   output logic [WIDTH_W-1:0] cnt_nxt
);

   localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

   always_comb begin
      if (line_start)
         cnt_nxt = '0;
      else if (dma_ack && cnt_q != CNT_MAX)
         cnt_nxt = cnt_q + 1'b1;
      else
         cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> cnt_q == '0);                                      // R5
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && dma_ack && cnt_q != CNT_MAX)
         |=> cnt_q == $past(cnt_q) + 1'b1);                            // R4
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && !dma_ack) |=> $stable(cnt_q));                   // R4

endmodule

// File: rtl/vft_req_gen.sv
module vft_req_gen
   import vft_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             inhibit_nxt,
   output logic             dma_req
);

   localparam logic [LVL_W-1:0] LOW_MARK  = LVL_W'(low_water(FIFO_DEPTH));
   localparam logic [LVL_W-1:0] FULL_MARK = LVL_W'(FIFO_DEPTH);

   req_state_e st_q, st_nxt;

   always_comb begin
      st_nxt = st_q;
      if (inhibit_nxt) begin
         st_nxt = REQ_IDLE;
      end else begin
         unique case (st_q)
            REQ_IDLE: if (fifo_level < LOW_MARK)   st_nxt = REQ_FILL;
            REQ_FILL: if (fifo_level >= FULL_MARK) st_nxt = REQ_IDLE;
            default:                               st_nxt = REQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= REQ_IDLE;
      else        st_q <= st_nxt;
   end

   assign dma_req = (st_q == REQ_FILL);

   initial begin
      assert (FIFO_DEPTH >= 4 && FIFO_DEPTH % 2 == 0)
         else $error("vft_req_gen: FIFO_DEPTH must be even and at least 4");
   end

   AST_LOW_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level < LOW_MARK && !inhibit_nxt) |=> dma_req);           // R2
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level >= FULL_MARK |=> !dma_req);                           // R3
   AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit_nxt && fifo_level >= LOW_MARK && fifo_level < FULL_MARK)
         |=> dma_req == $past(dma_req));                               // R3

endmodule

// File: rtl/vfifo_dma_throttle.sv
module vfifo_dma_throttle #(
   parameter int unsigned WIDTH_W        = 13,
   parameter int unsigned PRE_W          = 2,
   parameter int unsigned FIFO_DEPTH     = 16,
   parameter bit          HSYNC_ACT_HIGH = 1'b1,
   localparam int unsigned LVL_W         = $clog2(FIFO_DEPTH + 1),
   localparam int unsigned CFG_W         = WIDTH_W + 1 + PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             dma_ack,
   output logic             dma_req
);

   logic               line_start;
   logic [WIDTH_W-1:0] width_nxt, width_q;
   logic               enforce_nxt, enforce_q;
   logic [WIDTH_W-1:0] cnt_q, cnt_nxt;
   logic               inhibit_nxt;

   vft_cfg_shadow #(
      .WIDTH_W        (WIDTH_W),
      .PRE_W          (PRE_W),
      .HSYNC_ACT_HIGH (HSYNC_ACT_HIGH)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .hsync       (hsync),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .line_start  (line_start),
      .width_nxt   (width_nxt),
      .enforce_nxt (enforce_nxt),
      .width_q     (width_q),
      .enforce_q   (enforce_q)
   );

   vft_word_counter #(
      .WIDTH_W (WIDTH_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .dma_ack    (dma_ack),
      .cnt_q      (cnt_q),
      .cnt_nxt    (cnt_nxt)
   );

   assign inhibit_nxt = enforce_nxt && (cnt_nxt >= width_nxt);

   vft_req_gen #(
      .FIFO_DEPTH (FIFO_DEPTH)
   ) u_req (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_level  (fifo_level),
      .inhibit_nxt (inhibit_nxt),
      .dma_req     (dma_req)
   );

   AST_REQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (enforce_q && cnt_q >= width_q) |-> !dma_req);                   // R4
   AST_BYPASS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!enforce_nxt && fifo_level < LVL_W'(FIFO_DEPTH / 2)) |=> dma_req); // R6 R7

endmodule

// File: tb/vfifo_dma_throttle_bench.sv
`timescale 1ns/1ps
module vfifo_dma_throttle_bench;

   localparam int WW    = 13;
   localparam int DEPTH = 16;
   localparam int LW    = 5;
   localparam int CW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hsync = 1'b0;
   logic [LW-1:0] fifo_level = '0;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_wdata = '0;
   logic          dma_ack = 1'b0;
   logic          dma_req;

   always #2.5 clk = ~clk;

   vfifo_dma_throttle u_vfifo_dma_throttle (
      .clk (clk), .rst_n (rst_n), .hsync (hsync), .fifo_level (fifo_level),
      .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .dma_ack (dma_ack),
      .dma_req (dma_req)
   );

   // behavioural reference state
   bit        m_hs;
   bit [15:0] m_pend, m_act;
   int        m_cnt;
   bit        m_req;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string tag = "R1";

   function automatic logic [CW-1:0] mkcfg(int width, bit dis, int pre);
      return {pre[1:0], dis, width[12:0]};
   endfunction

   task automatic model_step();
      bit        rise;
      bit [15:0] act_n;
      int        cnt_n;
      bit        enf;
      bit        inh;
      if (!rst_n) begin
         m_hs = 0; m_pend = '0; m_act = '0; m_cnt = 0; m_req = 0;
         return;
      end
      rise  = hsync && !m_hs;
      act_n = rise ? m_pend : m_act;
      if (rise)                          cnt_n = 0;
      else if (dma_ack && m_cnt < 8191)  cnt_n = m_cnt + 1;
      else                               cnt_n = m_cnt;
      enf = !act_n[13] && (act_n[15:14] != 2'd0);
      inh = enf && (cnt_n >= int'(act_n[12:0]));
      m_req = !inh && ((int'(fifo_level) < DEPTH/2) ||
                       (m_req && int'(fifo_level) < DEPTH));
      if (cfg_we) m_pend = cfg_wdata;
      m_act = act_n;
      m_cnt = cnt_n;
      m_hs  = hsync;
   endtask

   task automatic check();
      n_chk++;
      if (dma_req !== m_req) begin
         n_fail++;
         $display("FAIL %s: dma_req actual %0b expected %0b at %0t",
                  tag, dma_req, m_req, $time);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check();
   endtask

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic wr(logic [CW-1:0] v);
      cfg_we = 1'b1; cfg_wdata = v; cycle(); cfg_we = 1'b0;
   endtask

   task automatic pulse_hs(int hi);
      hsync = 1'b1; cycles(hi); hsync = 1'b0; cycle();
   endtask

   task automatic acks(int n);
      dma_ack = 1'b1; cycles(n); dma_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      tag = "R1";
      @(negedge clk);
      fifo_level = 5'd2;
      cycles(3);
      rst_n = 1'b1;
      cycle();                       // first edge after reset: budget inactive
      cycles(2);

      // R2 / R3: hysteresis with no budget active
      tag = "R2"; fifo_level = 5'd7;  cycles(2);
      tag = "R3"; fifo_level = 5'd12; cycles(3);
      fifo_level = 5'd16; cycles(2);
      fifo_level = 5'd9;  cycles(3);
      fifo_level = 5'd8;  cycles(2);
      tag = "R2"; fifo_level = 5'd0; cycles(2);
      tag = "R3"; fifo_level = 5'd15; cycles(2);

      // R8: write budget of 5 mid-raster; must not bite before sync
      tag = "R8"; fifo_level = 5'd3;
      wr(mkcfg(5, 1'b0, 1));
      acks(10);
      cycles(2);

      // R4: budget active after sync, request drops at 5th ack
      tag = "R4";
      pulse_hs(1);
      acks(4); cycles(2);
      acks(1); cycles(3);
      acks(3); cycles(2);

      // R9: long sync pulse clears once only
      tag = "R9";
      hsync = 1'b1; cycle();
      acks(6); cycles(3);
      hsync = 1'b0; cycles(2);

      // R5: ack in same cycle as sync edge is not counted
      tag = "R5";
      hsync = 1'b1; dma_ack = 1'b1; cycle();
      hsync = 1'b0; acks(4); cycles(2);
      acks(1); cycles(2);

      // R8: write coinciding with sync edge waits one more raster
      tag = "R8";
      hsync = 1'b1; cfg_we = 1'b1; cfg_wdata = mkcfg(2, 1'b0, 2); cycle();
      cfg_we = 1'b0; hsync = 1'b0; cycle();
      acks(3); cycles(2);
      pulse_hs(1);
      acks(2); cycles(2);

      // R4: zero budget inhibits whole raster
      tag = "R4";
      wr(mkcfg(0, 1'b0, 3));
      pulse_hs(1);
      cycles(4);

      // R6: disable bit bypasses the budget
      tag = "R6";
      wr(mkcfg(3, 1'b1, 1));
      pulse_hs(1);
      acks(12); cycles(2);

      // R7: preload field zero bypasses the budget
      tag = "R7";
      wr(mkcfg(2, 1'b0, 0));
      pulse_hs(1);
      acks(12); cycles(2);

      // randomized mix compared cycle by cycle (R2 R3 R4 R5 R8)
      tag = "R4";
      for (int i = 0; i < 4000; i++) begin
         fifo_level = 5'($urandom_range(0, DEPTH));
         dma_ack    = ($urandom_range(0, 2) != 0);
         hsync      = ($urandom_range(0, 40) == 0) ? ~hsync : hsync;
         cfg_we     = ($urandom_range(0, 60) == 0);
         cfg_wdata  = mkcfg($urandom_range(0, 20), ($urandom_range(0, 5) == 0),
                            $urandom_range(0, 3));
         cycle();
      end
      cfg_we = 1'b0; dma_ack = 1'b0;
      cycles(2);

      finish_run();
   end

endmodule